// File: doc/BRIEF.md
# MII Nibble Frame Capture

This block watches a 4-bit MII-style transmit interface (data nibble, enable, interface clock) and records one Ethernet frame at a time into an internal byte store. The block runs on a fast system clock. It oversamples the interface clock and acts on each falling edge it sees. At each such edge it takes the enable and the nibble as they stand at that moment.

When a frame starts, the block throws away a fixed run of nibbles that carry the preamble and start-of-frame delimiter. It then pairs the remaining nibbles into bytes and writes them to consecutive buffer locations. When the enable is seen low, it raises a single-cycle completion strobe. Along with the strobe it presents the byte count and three condition flags: overflow, odd trailing nibble, and frame abandoned during the preamble.

The status stays on the outputs until the next completion. The stored bytes can be read back through a registered read port at any time, until the next frame overwrites them.

Top module: `mii_frame_capture`

## Requirements
- R1: After a synchronous active-high reset, `done` is 0 and `frame_len`, `overflow`, `dribble` and `abort` are all 0.
- R2: A frame starts at the first sampling edge where the enable is high after a sampling edge where it was low. That sampling edge and the next SKIP_NIBS-1 sampling edges (16 in total by default: seven preamble bytes and one delimiter byte) give nibbles that are discarded. The first stored byte therefore comes from nibbles 17 and 18.
- R3: Within each byte, the first nibble received becomes bits [3:0] and the second becomes bits [7:4]. The byte is stored at index `frame_len`-so-far once its upper nibble arrives, and the index then advances by one.
- R4: Enable and nibble are taken only at falling edges of `mii_clk`. A nibble value that is present at the rising edge and replaced before the falling edge has no effect.
- R5: At the first sampling edge with the enable low during data capture, `done` is high for exactly one system-clock cycle. `frame_len` then equals the number of complete bytes received, which may be zero.
- R6: If an odd nibble is left over when the enable falls, `dribble` is 1 with `done`, and that nibble is neither stored nor counted.
- R7: At most DEPTH bytes (default 1536) are stored. Later bytes are dropped, and `frame_len` stays at DEPTH. `overflow` is 1 with `done` only if at least one byte was dropped, so a frame of exactly DEPTH bytes reports `overflow` as 0.
- R8: If the enable is seen low before all SKIP_NIBS nibbles have been discarded, `done` is pulsed with `frame_len` = 0 and `abort` = 1.
- R9: `rd_data` shows, one system-clock cycle after `rd_addr` is applied, the byte stored at that index. For indices at or above DEPTH it shows 0.
- R10: `frame_len` and the flags keep their values from one `done` pulse until the next one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4x the interface clock |
| rst | input | 1 | Synchronous active-high reset |
| mii_clk | input | 1 | Interface clock, sampled by `clk` |
| mii_en | input | 1 | Interface transmit enable |
| mii_nib | input | 4 | Interface data nibble |
| rd_addr | input | ADDR_W (11) | Buffer read index |
| rd_data | output | 8 | Byte at `rd_addr`, one cycle later |
| done | output | 1 | One-cycle frame completion strobe |
| frame_len | output | LEN_W (11) | Bytes stored in the last frame |
| overflow | output | 1 | Last frame had bytes dropped |
| dribble | output | 1 | Last frame ended on an odd nibble |
| abort | output | 1 | Last frame ended inside the preamble skip |

## Verification
The checks assume that `mii_clk` stays high for at least two and low for at least two system-clock cycles. They also assume that enable and nibble hold steady from shortly before each falling edge of `mii_clk` until its next rising edge. Under those conditions every interface edge yields exactly one sampling event. The stimulus drives each interface cycle as four system-clock cycles high and four low, and changes enable and data only while `mii_clk` is high. It puts a wrong nibble on the bus at the rising edge and the correct one halfway through the high phase, so the correct value is in place well before the falling edge.

// File: rtl/mcap_pkg.sv
package mcap_pkg;

    localparam int NIB_W  = 4;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        CAP_IDLE,
        CAP_SKIP,
        CAP_DATA
    } cap_state_e;

    typedef struct packed {
        logic             en;
        logic [NIB_W-1:0] nib;
    } mii_sample_t;

    typedef struct packed {
        logic overflow;
        logic dribble;
        logic abort;
    } cap_flags_t;

    function automatic logic [BYTE_W-1:0] join_nibbles(
        input logic [NIB_W-1:0] lo,
        input logic [NIB_W-1:0] hi
    );
        return {hi, lo};
    endfunction

endpackage

// File: rtl/mcap_sampler.sv
module mcap_sampler
    import mcap_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             mii_clk,
    input  logic             mii_en,
    input  logic [NIB_W-1:0] mii_nib,
    output logic             strobe,
    output mii_sample_t      smp
);

    logic        clk_s;
    logic        clk_d;
    mii_sample_t raw_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            clk_s <= 1'b0;
            clk_d <= 1'b0;
            raw_q <= '0;
        end else begin
            clk_s <= mii_clk;
            clk_d <= clk_s;
            raw_q <= '{en: mii_en, nib: mii_nib};
        end
    end

    assign strobe = clk_d & ~clk_s;
    assign smp    = raw_q;

    AST_STROBE_ISOLATED: assert property (@(posedge clk) disable iff (rst)
        strobe |=> !strobe);  // R4

endmodule

// File: rtl/mcap_buffer.sv
module mcap_buffer
    import mcap_pkg::*;
#(
    parameter int DEPTH  = 1536,
    parameter int ADDR_W = $clog2(DEPTH)
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [BYTE_W-1:0] rd_data
);

    logic [BYTE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en && (int'(wr_addr) < DEPTH)) begin
            mem[wr_addr] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
        end else if (int'(rd_addr) < DEPTH) begin
            rd_data <= mem[rd_addr];
        end else begin
            rd_data <= '0;
        end
    end

    AST_WRITE_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (int'(wr_addr) < DEPTH));  // R7

endmodule

// File: rtl/mcap_assembler.sv
module mcap_assembler
    import mcap_pkg::*;
#(
    parameter int DEPTH     = 1536,
    parameter int SKIP_NIBS = 16,
    parameter int ADDR_W    = $clog2(DEPTH),
    parameter int LEN_W     = $clog2(DEPTH + 1)
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              strobe,
    input  mii_sample_t       smp,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [BYTE_W-1:0] wr_data,
    output logic              done,
    output logic [LEN_W-1:0]  frame_len,
    output cap_flags_t        flags
);

    localparam int SKIP_W = $clog2(SKIP_NIBS + 1);
    localparam logic [SKIP_W-1:0] SKIP_LAST = SKIP_W'(SKIP_NIBS - 1);
    localparam logic [LEN_W-1:0]  LEN_MAX   = LEN_W'(DEPTH);

    cap_state_e        state;
    logic [SKIP_W-1:0] skip_cnt;
    logic              phase;
    logic [NIB_W-1:0]  lo_nib;
    logic [LEN_W-1:0]  byte_cnt;
    logic              ovf;
    logic              en_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= CAP_IDLE;
            skip_cnt  <= '0;
            phase     <= 1'b0;
            lo_nib    <= '0;
            byte_cnt  <= '0;
            ovf       <= 1'b0;
            en_prev   <= 1'b0;
            wr_en     <= 1'b0;
            wr_addr   <= '0;
            wr_data   <= '0;
            done      <= 1'b0;
            frame_len <= '0;
            flags     <= '0;
        end else begin
            done  <= 1'b0;
            wr_en <= 1'b0;
            if (strobe) begin
                en_prev <= smp.en;
                unique case (state)
                    CAP_IDLE: begin
                        if (smp.en && !en_prev) begin
                            skip_cnt <= SKIP_W'(1);
                            byte_cnt <= '0;
                            phase    <= 1'b0;
                            ovf      <= 1'b0;
                            state    <= (SKIP_NIBS <= 1) ? CAP_DATA : CAP_SKIP;
                        end
                    end
                    CAP_SKIP: begin
                        if (!smp.en) begin
                            done      <= 1'b1;
                            frame_len <= '0;
                            flags     <= '{overflow: 1'b0, dribble: 1'b0, abort: 1'b1};
                            state     <= CAP_IDLE;
                        end else if (skip_cnt == SKIP_LAST) begin
                            state <= CAP_DATA;
                        end else begin
                            skip_cnt <= skip_cnt + 1'b1;
                        end
                    end
                    CAP_DATA: begin
                        if (!smp.en) begin
                            done      <= 1'b1;
                            frame_len <= byte_cnt;
                            flags     <= '{overflow: ovf, dribble: phase, abort: 1'b0};
                            phase     <= 1'b0;
                            state     <= CAP_IDLE;
                        end else if (!phase) begin
                            lo_nib <= smp.nib;
                            phase  <= 1'b1;
                        end else begin
                            phase <= 1'b0;
                            if (byte_cnt < LEN_MAX) begin
                                wr_en    <= 1'b1;
                                wr_addr  <= byte_cnt[ADDR_W-1:0];
                                wr_data  <= join_nibbles(lo_nib, smp.nib);
                                byte_cnt <= byte_cnt + 1'b1;
                            end else begin
                                ovf <= 1'b1;
                            end
                        end
                    end
                    default: state <= CAP_IDLE;
                endcase
            end
        end
    end

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);  // R5
    AST_LEN_BOUND: assert property (@(posedge clk) disable iff (rst)
        done |-> (frame_len <= LEN_MAX));  // R7
    AST_ABORT_ZERO: assert property (@(posedge clk) disable iff (rst)
        (done && flags.abort) |-> (frame_len == '0));  // R8
    AST_OVF_FULL: assert property (@(posedge clk) disable iff (rst)
        (done && flags.overflow) |-> (frame_len == LEN_MAX));  // R7
    AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (rst)
        !done |=> ($stable(frame_len) || done));  // R10
    AST_IDLE_EVEN: assert property (@(posedge clk) disable iff (rst)
        (state == CAP_IDLE) |-> !phase);  // R3

endmodule

// File: rtl/mii_frame_capture.sv
module mii_frame_capture
    import mcap_pkg::*;
#(
    parameter int DEPTH     = 1536,
    parameter int SKIP_NIBS = 16,
    localparam int ADDR_W   = $clog2(DEPTH),
    localparam int LEN_W    = $clog2(DEPTH + 1)
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              mii_clk,
    input  logic              mii_en,
    input  logic [3:0]        mii_nib,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic              done,
    output logic [LEN_W-1:0]  frame_len,
    output logic              overflow,
    output logic              dribble,
    output logic              abort
);

    logic              strobe;
    mii_sample_t       smp;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [BYTE_W-1:0] wr_data;
    cap_flags_t        flags;

    mcap_sampler u_sampler (
        .clk     (clk),
        .rst     (rst),
        .mii_clk (mii_clk),
        .mii_en  (mii_en),
        .mii_nib (mii_nib),
        .strobe  (strobe),
        .smp     (smp)
    );

    mcap_assembler #(
        .DEPTH     (DEPTH),
        .SKIP_NIBS (SKIP_NIBS),
        .ADDR_W    (ADDR_W),
        .LEN_W     (LEN_W)
    ) u_assembler (
        .clk       (clk),
        .rst       (rst),
        .strobe    (strobe),
        .smp       (smp),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .done      (done),
        .frame_len (frame_len),
        .flags     (flags)
    );

    mcap_buffer #(
        .DEPTH  (DEPTH),
        .ADDR_W (ADDR_W)
    ) u_buffer (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    assign overflow = flags.overflow;
    assign dribble  = flags.dribble;
    assign abort    = flags.abort;

    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        done |-> !(abort && (overflow || dribble)));  // R8

endmodule

// File: tb/tb_mii_frame_capture.sv
`timescale 1ns/1ps
module tb_mii_frame_capture;

    localparam int DEPTH  = 1536;
    localparam int ADDR_W = $clog2(DEPTH);
    localparam int LEN_W  = $clog2(DEPTH + 1);

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              mii_clk = 1'b0;
    logic              mii_en = 1'b0;
    logic [3:0]        mii_nib = 4'h0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic [7:0]        rd_data;
    logic              done;
    logic [LEN_W-1:0]  frame_len;
    logic              overflow, dribble, abort;

    always #4 clk = ~clk;

    mii_frame_capture dut (
        .clk(clk), .rst(rst), .mii_clk(mii_clk), .mii_en(mii_en), .mii_nib(mii_nib),
        .rd_addr(rd_addr), .rd_data(rd_data), .done(done), .frame_len(frame_len),
        .overflow(overflow), .dribble(dribble), .abort(abort)
    );

    int n_chk = 0;
    int n_bad = 0;
    int n_done = 0;
    int n_double = 0;
    logic prev_done = 1'b0;
    bit finished = 1'b0;

    // vector: {nbytes[11:0], odd nibble, seed[7:0]}
    localparam int NVEC = 7;
    localparam logic [20:0] VEC [NVEC] = '{
        {12'd1,  1'b0, 8'h11},
        {12'd2,  1'b1, 8'h20},
        {12'd46, 1'b0, 8'h3C},
        {12'd60, 1'b1, 8'h7E},
        {12'd0,  1'b0, 8'h05},
        {12'd0,  1'b1, 8'h09},
        {12'd9,  1'b0, 8'hC3}
    };

    always @(negedge clk) begin
        if (!rst) begin
            if (done) n_done++;
            if (done && prev_done) n_double++;
            prev_done = done;
        end else begin
            prev_done = 1'b0;
        end
    end

    function automatic logic [7:0] bval(input logic [7:0] seed, input int k);
        return 8'(int'(seed) + k * 37 + (k >> 8));
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // one interface cycle: wrong nibble at the rise, correct one mid-high (R4)
    task automatic tick(input logic en, input logic [3:0] nib);
        @(negedge clk);
        mii_clk = 1'b1;
        mii_en  = en;
        mii_nib = ~nib;
        repeat (2) @(negedge clk);
        mii_nib = nib;
        repeat (2) @(negedge clk);
        mii_clk = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic send_frame(input int nbytes, input bit odd, input logic [7:0] seed,
                              input int pre_nibs);
        n_done = 0;
        n_double = 0;
        tick(1'b0, 4'h0);
        tick(1'b0, 4'h0);
        for (int i = 0; i < pre_nibs; i++) tick(1'b1, (i == 15) ? 4'hD : 4'h5);
        for (int k = 0; k < nbytes; k++) begin
            tick(1'b1, bval(seed, k)[3:0]);
            tick(1'b1, bval(seed, k)[7:4]);
        end
        if (odd) tick(1'b1, 4'hA);
        for (int i = 0; i < 3; i++) tick(1'b0, 4'h0);
    endtask

    task automatic readback(input int nbytes, input logic [7:0] seed, input string req);
        int miss;
        miss = 0;
        for (int k = 0; k < nbytes; k++) begin
            @(negedge clk);
            rd_addr = ADDR_W'(k);
            @(negedge clk);
            if (rd_data !== bval(seed, k)) miss++;
        end
        check(req, miss, 0);
    endtask

    task automatic expect_done(input int len, input bit ovf, input bit drb, input bit abt);
        check("R5 one done pulse", n_done, 1);
        check("R5 done single cycle", n_double, 0);
        check("R5/R7 frame_len", int'(frame_len), len);
        check("R7 overflow", int'(overflow), int'(ovf));
        check("R6 dribble", int'(dribble), int'(drb));
        check("R8 abort", int'(abort), int'(abt));
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R1 reset state
        check("R1 done", int'(done), 0);
        check("R1 frame_len", int'(frame_len), 0);
        check("R1 flags", int'({overflow, dribble, abort}), 0);
        rst = 1'b0;
        repeat (4) @(negedge clk);

        // table-driven frames (R2, R3, R4, R5, R6, R9)
        for (int v = 0; v < NVEC; v++) begin
            int nb;
            nb = int'(VEC[v][20:9]);
            send_frame(nb, VEC[v][8], VEC[v][7:0], 16);
            expect_done(nb, 1'b0, VEC[v][8], 1'b0);
            readback(nb, VEC[v][7:0], "R2/R3/R4/R9 stored bytes");
        end

        // R10: status held across idle time, no extra done
        repeat (40) @(negedge clk);
        check("R10 frame_len held", int'(frame_len), 9);
        check("R10 no extra done", n_done, 1);

        // R8: enable drops during preamble skip
        send_frame(0, 1'b0, 8'h00, 9);
        expect_done(0, 1'b0, 1'b0, 1'b1);

        // R9: out-of-range read index returns zero
        @(negedge clk);
        rd_addr = ADDR_W'(DEPTH + 5);
        @(negedge clk);
        check("R9 out-of-range read", int'(rd_data), 0);

        // R7: exactly DEPTH bytes, no overflow
        send_frame(DEPTH, 1'b0, 8'h4B, 16);
        expect_done(DEPTH, 1'b0, 1'b0, 1'b0);
        readback(DEPTH, 8'h4B, "R7 full buffer contents");

        // R7: more than DEPTH bytes, extras dropped
        send_frame(DEPTH + 3, 1'b1, 8'h92, 16);
        expect_done(DEPTH, 1'b1, 1'b1, 1'b0);
        readback(DEPTH, 8'h92, "R7 overflow kept first bytes");

        // R1: reset clears held status
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 reset clears len", int'(frame_len), 0);
        check("R1 reset clears flags", int'({overflow, dribble, abort}), 0);
        rst = 1'b0;

        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule